// File: doc/BRIEF.md
# Second-Level Cache Snoop Controller

This block watches a shared memory bus for write cycles that other bus masters drive, and compares each write address with the tag store of a small direct-mapped second-level cache. The cache has 16 lines of 16 bytes. When a foreign write hits a resident line, the block does one of two things, chosen by a mode input. It either drops the line from the cache, or it merges the master's write data into the cached copy ("snarfing"), so that the line stays usable.

For every foreign write, whether it hits or misses, the block sends the write address to the processor's first-level cache as a single-cycle invalidation strobe. Each line carries a dirty flag that the local side sets when it updates the line without writing memory. A foreign write that lands on a dirty line means the memory copy was stale, so the block reports that case as its own event.

A local port loads lines and marks them dirty. A combinational lookup port returns the hit status, dirty status and word contents for any address.

Top module: `l2_snoop_ctrl`

## Requirements
- R1: Every cycle with `bus_wr_valid_i` high raises `l1_inv_o` for exactly one cycle, one clock later, with `l1_inv_addr_o` equal to the sampled `bus_addr_i`. This happens whether the write hits or misses.
- R2: Address bits [3:0] select the byte in the line, bits [3:2] select the 32-bit word, bits [7:4] select the line and bits [31:8] form the tag. A snoop hits when the selected line is valid and its tag matches. `snoop_hit_o` reports this in the same cycle as the strobe.
- R3: With `snarf_mode_i`=0, a snoop hit clears the line's valid and dirty flags at the clock edge that samples the write.
- R4: With `snarf_mode_i`=1, a snoop hit writes each byte lane whose `bus_be_i` bit n is set (data bits 8n+7:8n) into the addressed word. The other bytes are left unchanged, the line stays valid, and its dirty flag is unchanged.
- R5: `snoop_dirty_o` is high with the strobe when the hit line was dirty, and it is never high without `snoop_hit_o`.
- R6: A snoop miss changes no tag, valid, dirty or data state.
- R7: A local write (`loc_req_i`) stores the enabled bytes, loads the tag, sets the line valid and sets its dirty flag to `loc_dirty_i`.
- R8: If a local write and a foreign write target the same line index in the same cycle, the local write is discarded. If they target different indices, both take effect.
- R9: After reset, every line is invalid and all strobe outputs are low.
- R10: `rd_hit_o`, `rd_dirty_o` and `rd_data_o` show the current state of `rd_addr_i` combinationally. `rd_dirty_o` is high only together with `rd_hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_valid_i | input | 1 | Foreign master write on the bus this cycle |
| bus_addr_i | input | 32 | Foreign write address |
| bus_data_i | input | 32 | Foreign write data |
| bus_be_i | input | 4 | Foreign write byte enables |
| snarf_mode_i | input | 1 | 1: merge data on hit, 0: invalidate on hit |
| loc_req_i | input | 1 | Local write/fill request |
| loc_dirty_i | input | 1 | Dirty value given to the written line |
| loc_addr_i | input | 32 | Local write address |
| loc_data_i | input | 32 | Local write data |
| loc_be_i | input | 4 | Local write byte enables |
| rd_addr_i | input | 32 | Lookup address |
| rd_hit_o | output | 1 | Lookup hits a valid line |
| rd_dirty_o | output | 1 | Lookup hits a dirty line |
| rd_data_o | output | 32 | Word held at the lookup address |
| l1_inv_o | output | 1 | Invalidation strobe to the first-level cache |
| l1_inv_addr_o | output | 32 | Address sent with the strobe |
| snoop_hit_o | output | 1 | Last snoop hit the cache |
| snoop_dirty_o | output | 1 | Last snoop hit a dirty line |

## Verification
The assertions check on every cycle that each bus write produces the forwarding strobe one clock later with the latched address, and that no strobe appears without a write. They also check that a dirty-hit flag never appears without a hit. Two further assertions follow the lookup port after a snoop: a line hit in invalidate mode must then miss, and a snarf must leave its line's hit status unchanged. Only the bench scenarios can show the byte-lane merge results, the dirty flag surviving a snarf, a miss leaving neighbouring lines intact, and a same-index local write being discarded while a different-index one is kept.

// File: rtl/l2_snoop_pkg.sv
package l2_snoop_pkg;
  typedef enum logic {
    SNOOP_INVAL = 1'b0,
    SNOOP_SNARF = 1'b1
  } snoop_mode_e;

  typedef struct packed {
    logic hit;
    logic dirty;
  } lookup_t;
endpackage

// File: rtl/l2_tag_store.sv
module l2_tag_store
  import l2_snoop_pkg::*;
#(
  parameter int unsigned LINES = 16,
  parameter int unsigned IDX_W = $clog2(LINES),
  parameter int unsigned TAG_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] sn_idx_i,
  input  logic [TAG_W-1:0] sn_tag_i,
  output lookup_t          sn_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output lookup_t          rd_o,
  input  logic             inval_i,
  input  logic             loc_we_i,
  input  logic [IDX_W-1:0] loc_idx_i,
  input  logic [TAG_W-1:0] loc_tag_i,
  input  logic             loc_dirty_i
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    sn_o.hit   = valid_q[sn_idx_i] && (tag_q[sn_idx_i] == sn_tag_i);
    sn_o.dirty = sn_o.hit && dirty_q[sn_idx_i];
    rd_o.hit   = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    rd_o.dirty = rd_o.hit && dirty_q[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (inval_i && sn_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else if (loc_we_i && loc_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= loc_dirty_i;
          tag_q[i]   <= loc_tag_i;
        end
      end
    end
  end
endmodule

// File: rtl/l2_data_store.sv
module l2_data_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned SEL_W   = $clog2(ENTRIES),
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BE_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              sn_we_i,
  input  logic [SEL_W-1:0]  sn_sel_i,
  input  logic [DATA_W-1:0] sn_data_i,
  input  logic [BE_W-1:0]   sn_be_i,
  input  logic              loc_we_i,
  input  logic [SEL_W-1:0]  loc_sel_i,
  input  logic [DATA_W-1:0] loc_data_i,
  input  logic [BE_W-1:0]   loc_be_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  assign rd_data_o = mem_q[rd_sel_i];

  // snarf lanes win over local lanes on the same word
  always_ff @(posedge clk_i) begin
    for (int e = 0; e < ENTRIES; e++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (sn_we_i && sn_sel_i == SEL_W'(e) && sn_be_i[b])
          mem_q[e][b*8 +: 8] <= sn_data_i[b*8 +: 8];
        else if (loc_we_i && loc_sel_i == SEL_W'(e) && loc_be_i[b])
          mem_q[e][b*8 +: 8] <= loc_data_i[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/l2_snoop_fwd.sv
module l2_snoop_fwd #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hit_i,
  input  logic              dirty_i,
  output logic              inv_o,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic              hit_o,
  output logic              dirty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_o      <= 1'b0;
      inv_addr_o <= '0;
      hit_o      <= 1'b0;
      dirty_o    <= 1'b0;
    end else begin
      inv_o   <= wr_i;
      hit_o   <= wr_i & hit_i;
      dirty_o <= wr_i & dirty_i;
      if (wr_i) inv_addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/l2_snoop_ctrl.sv
module l2_snoop_ctrl
  import l2_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned BSEL_W = $clog2(BE_W),
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned WSEL_W = OFF_W - BSEL_W,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned SEL_W  = IDX_W + WSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic              snarf_mode_i,
  input  logic              loc_req_i,
  input  logic              loc_dirty_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [DATA_W-1:0] loc_data_i,
  input  logic [BE_W-1:0]   loc_be_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_hit_o,
  output logic              rd_dirty_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              l1_inv_o,
  output logic [ADDR_W-1:0] l1_inv_addr_o,
  output logic              snoop_hit_o,
  output logic              snoop_dirty_o
);
  lookup_t     sn_look, rd_look;
  snoop_mode_e mode;
  logic        inval, snarf, loc_we;
  logic        unused_low;

  assign unused_low = ^{loc_addr_i[BSEL_W-1:0], rd_addr_i[BSEL_W-1:0]};
  assign mode       = snoop_mode_e'(snarf_mode_i);

  wire [IDX_W-1:0] bus_idx = bus_addr_i[OFF_W +: IDX_W];
  wire [IDX_W-1:0] loc_idx = loc_addr_i[OFF_W +: IDX_W];
  wire [IDX_W-1:0] rd_idx  = rd_addr_i[OFF_W +: IDX_W];

  assign inval  = bus_wr_valid_i && sn_look.hit && (mode == SNOOP_INVAL);
  assign snarf  = bus_wr_valid_i && sn_look.hit && (mode == SNOOP_SNARF);
  // snoop owns the index for this cycle
  assign loc_we = loc_req_i && !(bus_wr_valid_i && bus_idx == loc_idx);

  l2_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sn_idx_i   (bus_idx),
    .sn_tag_i   (bus_addr_i[ADDR_W-1 -: TAG_W]),
    .sn_o       (sn_look),
    .rd_idx_i   (rd_idx),
    .rd_tag_i   (rd_addr_i[ADDR_W-1 -: TAG_W]),
    .rd_o       (rd_look),
    .inval_i    (inval),
    .loc_we_i   (loc_we),
    .loc_idx_i  (loc_idx),
    .loc_tag_i  (loc_addr_i[ADDR_W-1 -: TAG_W]),
    .loc_dirty_i(loc_dirty_i)
  );

  l2_data_store #(.ENTRIES(LINES * (1 << WSEL_W)), .SEL_W(SEL_W), .DATA_W(DATA_W),
                  .BE_W(BE_W)) u_data (
    .clk_i     (clk_i),
    .sn_we_i   (snarf),
    .sn_sel_i  (bus_addr_i[BSEL_W +: SEL_W]),
    .sn_data_i (bus_data_i),
    .sn_be_i   (bus_be_i),
    .loc_we_i  (loc_we),
    .loc_sel_i (loc_addr_i[BSEL_W +: SEL_W]),
    .loc_data_i(loc_data_i),
    .loc_be_i  (loc_be_i),
    .rd_sel_i  (rd_addr_i[BSEL_W +: SEL_W]),
    .rd_data_o (rd_data_o)
  );

  l2_snoop_fwd #(.ADDR_W(ADDR_W)) u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_valid_i),
    .addr_i    (bus_addr_i),
    .hit_i     (sn_look.hit),
    .dirty_i   (sn_look.dirty),
    .inv_o     (l1_inv_o),
    .inv_addr_o(l1_inv_addr_o),
    .hit_o     (snoop_hit_o),
    .dirty_o   (snoop_dirty_o)
  );

  assign rd_hit_o   = rd_look.hit;
  assign rd_dirty_o = rd_look.dirty;
endmodule

// File: rtl/l2_snoop_chk.sv
module l2_snoop_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_wr_valid_i,
  input logic [31:0] bus_addr_i,
  input logic        snarf_mode_i,
  input logic [31:0] rd_addr_i,
  input logic        rd_hit_o,
  input logic        rd_dirty_o,
  input logic        l1_inv_o,
  input logic [31:0] l1_inv_addr_o,
  input logic        snoop_hit_o,
  input logic        snoop_dirty_o
);
  // R1
  fwd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_valid_i |=> (l1_inv_o && l1_inv_addr_o == $past(bus_addr_i)));
  // R1
  no_spurious_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_valid_i |=> !l1_inv_o);
  // R5
  dirty_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_dirty_o |-> snoop_hit_o);
  // R3
  inval_drops_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_valid_i && !snarf_mode_i) |=>
      ((rd_addr_i[31:4] == $past(bus_addr_i[31:4])) |-> !rd_hit_o));
  // R4
  snarf_keeps_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_valid_i && snarf_mode_i) |=>
      ((rd_addr_i[31:4] == $past(bus_addr_i[31:4])) |-> (rd_hit_o == snoop_hit_o)));
  // R10
  rd_dirty_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dirty_o |-> rd_hit_o);
endmodule

bind l2_snoop_ctrl l2_snoop_chk u_chk (.*);

// File: tb/l2_snoop_ctrl_bench.sv
module l2_snoop_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, snarf = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [3:0]  bus_be = '0;
  logic        loc_req = 1'b0, loc_dirty = 1'b0;
  logic [31:0] loc_addr = '0, loc_data = '0;
  logic [3:0]  loc_be = '0;
  logic [31:0] rd_addr = '0;
  logic        rd_hit, rd_dirty, l1_inv, sn_hit, sn_dirty;
  logic [31:0] rd_data, l1_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  l2_snoop_ctrl u_l2_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_valid_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .bus_be_i(bus_be), .snarf_mode_i(snarf),
    .loc_req_i(loc_req), .loc_dirty_i(loc_dirty), .loc_addr_i(loc_addr),
    .loc_data_i(loc_data), .loc_be_i(loc_be), .rd_addr_i(rd_addr),
    .rd_hit_o(rd_hit), .rd_dirty_o(rd_dirty), .rd_data_o(rd_data),
    .l1_inv_o(l1_inv), .l1_inv_addr_o(l1_addr), .snoop_hit_o(sn_hit),
    .snoop_dirty_o(sn_dirty)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        snarf;
    logic        hit;
    logic        dhit;
    logic [31:0] rd_addr;
    logic        rd_hit;
    logic        rd_dirty;
    logic [31:0] rd_data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_9010, 32'hAAAA_AAAA, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0000_1010, 1'b1, 1'b0, 32'h1111_1111},
    '{32'h0000_1010, 32'hAABB_CCDD, 4'h5, 1'b1, 1'b1, 1'b0, 32'h0000_1010, 1'b1, 1'b0, 32'h11BB_11DD},
    '{32'h0000_1010, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 1'b0, 32'h0000_1010, 1'b0, 1'b0, 32'h0},
    '{32'h0000_2020, 32'h5A5A_5A5A, 4'hF, 1'b1, 1'b1, 1'b1, 32'h0000_2020, 1'b1, 1'b1, 32'h5A5A_5A5A},
    '{32'h0000_4048, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 1'b1, 32'h0000_4048, 1'b0, 1'b0, 32'h0},
    '{32'h0000_3034, 32'hEE00_0000, 4'h8, 1'b1, 1'b1, 1'b0, 32'h0000_3034, 1'b1, 1'b0, 32'hEE33_3333},
    '{32'h0000_3030, 32'h0000_0000, 4'hF, 1'b0, 1'b1, 1'b0, 32'h0000_3034, 1'b0, 1'b0, 32'h0},
    '{32'h0000_5050, 32'h0000_0000, 4'hF, 1'b0, 1'b0, 1'b0, 32'h0000_2020, 1'b1, 1'b1, 32'h5A5A_5A5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loc_write(input logic [31:0] a, input logic [31:0] d, input logic dty);
    @(negedge clk);
    loc_req = 1'b1; loc_addr = a; loc_data = d; loc_be = 4'hF; loc_dirty = dty;
    @(negedge clk);
    loc_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    rd_addr = 32'h0000_1010; #1;
    chk("R9 rd_hit", rd_hit, 0);
    chk("R9 l1_inv", l1_inv, 0);
    chk("R9 snoop_hit", sn_hit, 0);
    rst_n = 1'b1;

    // R7: preload
    loc_write(32'h0000_1010, 32'h1111_1111, 1'b0);
    loc_write(32'h0000_2020, 32'h2222_2222, 1'b1);
    loc_write(32'h0000_3034, 32'h3333_3333, 1'b0);
    loc_write(32'h0000_4048, 32'h4444_4444, 1'b1);
    rd_addr = 32'h0000_2020; #1;
    chk("R7 rd_hit", rd_hit, 1);
    chk("R7 rd_dirty", rd_dirty, 1);
    chk("R10 rd_data", rd_data, 32'h2222_2222);
    rd_addr = 32'h0000_1010; #1;
    chk("R7 clean line", rd_dirty, 0);

    // R1 R2 R3 R4 R5 R6: vector walk
    foreach (VECS[i]) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = VECS[i].addr; bus_data = VECS[i].data;
      bus_be = VECS[i].be; snarf = VECS[i].snarf;
      @(negedge clk);
      bus_wr = 1'b0; rd_addr = VECS[i].rd_addr; #1;
      chk($sformatf("R1 strobe v%0d", i), l1_inv, 1);
      chk($sformatf("R1 addr v%0d", i), l1_addr, VECS[i].addr);
      chk($sformatf("R2 hit v%0d", i), sn_hit, VECS[i].hit);
      chk($sformatf("R5 dirty hit v%0d", i), sn_dirty, VECS[i].dhit);
      chk($sformatf("R3/R4/R6 rd_hit v%0d", i), rd_hit, VECS[i].rd_hit);
      chk($sformatf("R4 rd_dirty v%0d", i), rd_dirty, VECS[i].rd_dirty);
      if (VECS[i].rd_hit) chk($sformatf("R4/R6 rd_data v%0d", i), rd_data, VECS[i].rd_data);
      @(negedge clk);
      chk($sformatf("R1 pulse v%0d", i), l1_inv, 0);
    end

    // R8: same index, local discarded
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_6060; snarf = 1'b0;
    loc_req = 1'b1; loc_addr = 32'h0000_6064; loc_data = 32'hDEAD_BEEF; loc_dirty = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; loc_req = 1'b0; rd_addr = 32'h0000_6064; #1;
    chk("R8 same index dropped", rd_hit, 0);

    // R8: different index, both kept
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_8080;
    loc_req = 1'b1; loc_addr = 32'h0000_7070; loc_data = 32'h7777_0000; loc_dirty = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; loc_req = 1'b0; rd_addr = 32'h0000_7070; #1;
    chk("R8 other index kept", rd_hit, 1);
    chk("R8 other index data", rd_data, 32'h7777_0000);
    chk("R8 snoop still forwarded", l1_inv, 1);

    // R8 with R3: hit invalidated, same-index refill discarded
    loc_write(32'h0000_9090, 32'h9999_9999, 1'b1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h0000_9090; snarf = 1'b0;
    loc_req = 1'b1; loc_addr = 32'h0000_9094; loc_data = 32'h1234_5678; loc_dirty = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; loc_req = 1'b0; rd_addr = 32'h0000_9094; #1;
    chk("R5 dirty hit", sn_dirty, 1);
    chk("R8 hit line invalid", rd_hit, 0);

    @(negedge clk);
    finish_run();
  end
endmodule